// File: doc/BRIEF.md
# Compiler-Hinted Issue Delay Controller

This block sits between an instruction buffer and the execution pipelines of a throughput processor core. Each incoming instruction carries a small stall count chosen by the compiler. When an instruction issues, the count is loaded into a per-warp down-counter. The next instruction of that warp is held back until the counter has drained. The issue logic never compares register operands for fixed-latency arithmetic. It relies on the compiler to cover the read-after-write gap of roughly ten to twelve cycles. That gap exists because results take the full register-file round trip and there is no forwarding path.

Memory loads have no fixed latency, so they are handled differently. Each warp has a scoreboard with one bit per architectural register. A load sets the bit for its destination, and a writeback port clears it. Any later instruction of that warp that reads a pending register as a source is held until the bit clears. The destination field is not checked against the scoreboard.

Arbitration between warps happens outside this block. Instructions arrive one at a time with a warp number on a valid/ready handshake. The block reports which warps have a drained stall counter through a per-warp ready vector.

Top module: `issue_delay_ctrl`

## Requirements
- R1: An instruction with no pending source register is accepted in the same cycle it is offered once its warp's counter is zero. Arithmetic operands are never compared, so an instruction with stall 0 followed by one reading its destination issues in consecutive cycles.
- R2: The stall field is 4 bits wide, giving values 0 to 15. After an instruction with stall S is accepted, the same warp's next instruction sees in_ready low for exactly S cycles before it can be accepted.
- R3: warp_ready[w] is high exactly when warp w's stall counter is zero. It goes low in the cycle after accepting an instruction with nonzero stall for that warp. A pending load alone does not lower it.
- R4: Stall counters and scoreboards are kept per warp. A stall or pending load in one warp never holds another warp.
- R5: Accepting an instruction with in_load=1 marks register in_dst of that warp as pending. A later instruction of the same warp whose in_src_a or in_src_b names a pending register is held with in_ready low.
- R6: wb_valid with wb_warp and wb_dst clears that warp's pending bit at the clock edge. A held consumer is accepted in the cycle after the writeback cycle. A writeback to another warp has no effect on the bit.
- R7: If a load to a register is accepted in the same cycle as a writeback to the same warp and register, the bit ends up set.
- R8: When both the stall counter and a pending source hold an instruction, it waits until both have cleared.
- R9: One cycle after each acceptance, iss_valid is high for one cycle, and iss_warp, iss_load, iss_dst, iss_src_a and iss_src_b carry the accepted fields. In a cycle after no acceptance, iss_valid is low.
- R10: After reset, all stall counters are zero (warp_ready all ones), no register is pending, and iss_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction is accepted this cycle |
| in_warp | input | WARP_W | Warp number of the offered instruction |
| in_load | input | 1 | The instruction is a variable-latency memory load |
| in_dst | input | REG_W | Destination register |
| in_src_a | input | REG_W | First source register |
| in_src_b | input | REG_W | Second source register |
| in_stall | input | STALL_W | Compiler-supplied stall count |
| wb_valid | input | 1 | A load result is written back |
| wb_warp | input | WARP_W | Warp of the writeback |
| wb_dst | input | REG_W | Register being written back |
| iss_valid | output | 1 | An instruction was issued |
| iss_warp | output | WARP_W | Warp of the issued instruction |
| iss_load | output | 1 | Issued instruction is a load |
| iss_dst | output | REG_W | Destination of the issued instruction |
| iss_src_a | output | REG_W | First source of the issued instruction |
| iss_src_b | output | REG_W | Second source of the issued instruction |
| warp_ready | output | NUM_WARPS | Per-warp stall counter drained |

## Verification
The properties assume that writebacks only name registers for which a load was issued. They also assume that in_warp is below NUM_WARPS and that inputs are stable while the clock is high. The directed stimulus obeys these rules. Every writeback it drives answers a load issued earlier in the same scenario, and every scenario ends with no register left pending. Writebacks aimed at an unrelated warp are still sent, but only toward registers that the bench expects to remain pending.

// File: rtl/idc_pkg.sv
package idc_pkg;

  // Why an offered instruction is being held this cycle.
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_STALL = 2'd1,
    HOLD_PEND  = 2'd2,
    HOLD_BOTH  = 2'd3
  } hold_e;

  // One step of the compiler stall countdown: saturating decrement.
  function automatic int unsigned count_step(int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

  // Merge the two hold sources into one reason code.
  function automatic hold_e hold_of(logic stall_busy, logic pend_hit);
    return hold_e'({pend_hit, stall_busy});
  endfunction

endpackage

// File: rtl/idc_stall_ctr.sv
module idc_stall_ctr #(
  parameter int STALL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [STALL_W-1:0] load_val,
  output logic               busy
);

  logic [STALL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_en) begin
      cnt_q <= load_val;
    end else begin
      cnt_q <= STALL_W'(idc_pkg::count_step(32'(cnt_q)));
    end
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/idc_pend_board.sv
module idc_pend_board #(
  parameter int NUM_REGS = 64,
  parameter int REG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_en,
  input  logic [REG_W-1:0]    set_idx,
  input  logic                clr_en,
  input  logic [REG_W-1:0]    clr_idx,
  input  logic [REG_W-1:0]    probe_a,
  input  logic [REG_W-1:0]    probe_b,
  output logic                hit,
  output logic [NUM_REGS-1:0] bits
);

  logic [NUM_REGS-1:0] bits_q;

  // Clear first, then set: a load landing with a writeback to the
  // same register leaves the register pending.
  function automatic logic [NUM_REGS-1:0] pend_next(
    logic [NUM_REGS-1:0] cur,
    logic                s_en,
    logic [REG_W-1:0]    s_idx,
    logic                c_en,
    logic [REG_W-1:0]    c_idx
  );
    logic [NUM_REGS-1:0] nxt;
    nxt = cur;
    if (c_en) nxt[c_idx] = 1'b0;
    if (s_en) nxt[s_idx] = 1'b1;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else begin
      bits_q <= pend_next(bits_q, set_en, set_idx, clr_en, clr_idx);
    end
  end

  assign hit  = bits_q[probe_a] | bits_q[probe_b];
  assign bits = bits_q;

endmodule

// File: rtl/idc_issue_reg.sv
module idc_issue_reg #(
  parameter int WARP_W = 2,
  parameter int REG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [WARP_W-1:0] warp,
  input  logic              load,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  output logic              o_valid,
  output logic [WARP_W-1:0] o_warp,
  output logic              o_load,
  output logic [REG_W-1:0]  o_dst,
  output logic [REG_W-1:0]  o_src_a,
  output logic [REG_W-1:0]  o_src_b
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_warp  <= '0;
      o_load  <= 1'b0;
      o_dst   <= '0;
      o_src_a <= '0;
      o_src_b <= '0;
    end else begin
      o_valid <= cap_en;
      if (cap_en) begin
        o_warp  <= warp;
        o_load  <= load;
        o_dst   <= dst;
        o_src_a <= src_a;
        o_src_b <= src_b;
      end
    end
  end

endmodule

// File: rtl/issue_delay_ctrl.sv
module issue_delay_ctrl #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  parameter int STALL_W   = 4,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WARP_W-1:0]    in_warp,
  input  logic                 in_load,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src_a,
  input  logic [REG_W-1:0]     in_src_b,
  input  logic [STALL_W-1:0]   in_stall,
  input  logic                 wb_valid,
  input  logic [WARP_W-1:0]    wb_warp,
  input  logic [REG_W-1:0]     wb_dst,
  output logic                 iss_valid,
  output logic [WARP_W-1:0]    iss_warp,
  output logic                 iss_load,
  output logic [REG_W-1:0]     iss_dst,
  output logic [REG_W-1:0]     iss_src_a,
  output logic [REG_W-1:0]     iss_src_b,
  output logic [NUM_WARPS-1:0] warp_ready
);

  localparam int PEND_BITS = NUM_WARPS * NUM_REGS;

  // Named internal events, visible to the bound checker.
  logic [NUM_WARPS-1:0] busy_w;
  logic [NUM_WARPS-1:0] hit_w;
  logic [PEND_BITS-1:0] pend_flat;
  logic                 sel_busy;
  logic                 sel_hit;
  idc_pkg::hold_e       hold_reason;
  logic                 fire;

  assign sel_busy    = busy_w[in_warp];
  assign sel_hit     = hit_w[in_warp];
  assign hold_reason = idc_pkg::hold_of(sel_busy, sel_hit);
  assign in_ready    = (hold_reason == idc_pkg::HOLD_NONE);
  assign fire        = in_valid && in_ready;
  assign warp_ready  = ~busy_w;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic this_in;
    logic this_wb;
    assign this_in = (in_warp == WARP_W'(w));
    assign this_wb = wb_valid && (wb_warp == WARP_W'(w));

    idc_stall_ctr #(
      .STALL_W (STALL_W)
    ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (fire && this_in),
      .load_val (in_stall),
      .busy     (busy_w[w])
    );

    idc_pend_board #(
      .NUM_REGS (NUM_REGS),
      .REG_W    (REG_W)
    ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (fire && this_in && in_load),
      .set_idx (in_dst),
      .clr_en  (this_wb),
      .clr_idx (wb_dst),
      .probe_a (in_src_a),
      .probe_b (in_src_b),
      .hit     (hit_w[w]),
      .bits    (pend_flat[w*NUM_REGS +: NUM_REGS])
    );
  end

  idc_issue_reg #(
    .WARP_W (WARP_W),
    .REG_W  (REG_W)
  ) u_iss (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (fire),
    .warp    (in_warp),
    .load    (in_load),
    .dst     (in_dst),
    .src_a   (in_src_a),
    .src_b   (in_src_b),
    .o_valid (iss_valid),
    .o_warp  (iss_warp),
    .o_load  (iss_load),
    .o_dst   (iss_dst),
    .o_src_a (iss_src_a),
    .o_src_b (iss_src_b)
  );

endmodule

// File: rtl/issue_delay_ctrl_chk.sv
module issue_delay_ctrl_chk #(
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 64,
  parameter int STALL_W   = 4,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int IDX_W    = WARP_W + REG_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [WARP_W-1:0]             in_warp,
  input logic                          in_load,
  input logic [REG_W-1:0]              in_dst,
  input logic [REG_W-1:0]              in_src_a,
  input logic [REG_W-1:0]              in_src_b,
  input logic [STALL_W-1:0]            in_stall,
  input logic                          wb_valid,
  input logic [WARP_W-1:0]             wb_warp,
  input logic [REG_W-1:0]              wb_dst,
  input logic                          iss_valid,
  input logic [WARP_W-1:0]             iss_warp,
  input logic [REG_W-1:0]              iss_dst,
  input logic [NUM_WARPS-1:0]          warp_ready,
  input logic                          fire,
  input logic [NUM_WARPS*NUM_REGS-1:0] pend_flat
);

  logic [IDX_W-1:0] ld_idx;
  logic [IDX_W-1:0] wb_idx;
  logic [IDX_W-1:0] pa_idx;
  logic [IDX_W-1:0] pb_idx;
  logic             same_slot;

  assign ld_idx    = {in_warp, in_dst};
  assign wb_idx    = {wb_warp, wb_dst};
  assign pa_idx    = {in_warp, in_src_a};
  assign pb_idx    = {in_warp, in_src_b};
  assign same_slot = fire && in_load && (ld_idx == wb_idx);

  AST_BLOCKED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !warp_ready[in_warp]) |-> !in_ready); // R2

  AST_STALL_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_stall != '0) |=> !warp_ready[$past(in_warp)]); // R3

  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (pend_flat[pa_idx] || pend_flat[pb_idx])) |-> !in_ready); // R5

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !same_slot) |=> !pend_flat[$past(wb_idx)]); // R6

  AST_LOAD_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_load) |=> pend_flat[$past(ld_idx)]); // R7

  AST_ISSUE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (iss_valid && iss_warp == $past(in_warp) && iss_dst == $past(in_dst))); // R9

  AST_NO_SPURIOUS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !iss_valid); // R9

endmodule

bind issue_delay_ctrl issue_delay_ctrl_chk #(
  .NUM_WARPS (NUM_WARPS),
  .NUM_REGS  (NUM_REGS),
  .STALL_W   (STALL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_warp    (in_warp),
  .in_load    (in_load),
  .in_dst     (in_dst),
  .in_src_a   (in_src_a),
  .in_src_b   (in_src_b),
  .in_stall   (in_stall),
  .wb_valid   (wb_valid),
  .wb_warp    (wb_warp),
  .wb_dst     (wb_dst),
  .iss_valid  (iss_valid),
  .iss_warp   (iss_warp),
  .iss_dst    (iss_dst),
  .warp_ready (warp_ready),
  .fire       (fire),
  .pend_flat  (pend_flat)
);

// File: tb/issue_delay_ctrl_tb.sv
module issue_delay_ctrl_tb;

  localparam int NW  = 4;
  localparam int NR  = 64;
  localparam int SW  = 4;
  localparam int WW  = $clog2(NW);
  localparam int RW  = $clog2(NR);
  localparam int FREE_A = 60;
  localparam int FREE_B = 61;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [WW-1:0] in_warp = '0;
  logic          in_load = 1'b0;
  logic [RW-1:0] in_dst = '0;
  logic [RW-1:0] in_src_a = '0;
  logic [RW-1:0] in_src_b = '0;
  logic [SW-1:0] in_stall = '0;
  logic          wb_valid = 1'b0;
  logic [WW-1:0] wb_warp = '0;
  logic [RW-1:0] wb_dst = '0;
  logic          iss_valid;
  logic [WW-1:0] iss_warp;
  logic          iss_load;
  logic [RW-1:0] iss_dst;
  logic [RW-1:0] iss_src_a;
  logic [RW-1:0] iss_src_b;
  logic [NW-1:0] warp_ready;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  issue_delay_ctrl #(.NUM_WARPS(NW), .NUM_REGS(NR), .STALL_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_warp(in_warp),
    .in_load(in_load), .in_dst(in_dst), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .in_stall(in_stall),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_dst(wb_dst),
    .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_load(iss_load),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .warp_ready(warp_ready)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Offer one instruction starting at a falling edge; count held cycles.
  // Returns at the falling edge after acceptance.
  task automatic send(input int w, input bit ld, input int dst, input int sa,
                      input int sb, input int st, output int waits);
    in_valid = 1'b1;
    in_warp  = WW'(w);
    in_load  = ld;
    in_dst   = RW'(dst);
    in_src_a = RW'(sa);
    in_src_b = RW'(sb);
    in_stall = SW'(st);
    waits = 0;
    #1;
    while (!in_ready && waits < 200) begin
      @(negedge clk);
      #1;
      waits++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drive_wb(input int delay, input int w, input int r);
    repeat (delay) @(negedge clk);
    wb_valid = 1'b1;
    wb_warp  = WW'(w);
    wb_dst   = RW'(r);
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", "warp_ready after reset", int'(warp_ready), (1 << NW) - 1);
    check("R10", "iss_valid after reset", int'(iss_valid), 0);
    in_src_a = RW'(5);
    in_src_b = RW'(33);
    check("R10", "nothing pending after reset", int'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic t_back_to_back;
    int wt;
    send(0, 1'b0, 3, FREE_A, FREE_B, 0, wt);
    check("R1", "first alu waits", wt, 0);
    #1;
    check("R9", "iss_valid after accept", int'(iss_valid), 1);
    check("R9", "iss_dst", int'(iss_dst), 3);
    check("R9", "iss_src_a", int'(iss_src_a), FREE_A);
    check("R9", "iss_warp", int'(iss_warp), 0);
    check("R9", "iss_load", int'(iss_load), 0);
    send(0, 1'b0, 4, 3, 3, 0, wt);
    check("R1", "dependent alu with stall 0 not compared", wt, 0);
    #1;
    check("R9", "second issue dst", int'(iss_dst), 4);
    @(negedge clk);
    #1;
    check("R9", "iss_valid low when idle", int'(iss_valid), 0);
  endtask

  task automatic t_stall;
    int wt;
    send(0, 1'b0, 7, FREE_A, FREE_B, 3, wt);
    #1;
    check("R3", "warp_ready after stall 3", int'(warp_ready), 4'b1110);
    send(0, 1'b0, 8, 7, FREE_B, 15, wt);
    check("R2", "held cycles for stall 3", wt, 3);
    send(0, 1'b0, 9, FREE_A, FREE_B, 0, wt);
    check("R2", "held cycles for stall 15", wt, 15);
    #1;
    check("R3", "warp_ready back high after stall 0", int'(warp_ready[0]), 1);
  endtask

  task automatic t_indep;
    int wt;
    send(0, 1'b0, 10, FREE_A, FREE_B, 10, wt);
    send(1, 1'b0, 11, FREE_A, FREE_B, 0, wt);
    check("R4", "other warp not held by stall", wt, 0);
    send(0, 1'b0, 12, FREE_A, FREE_B, 0, wt);
    check("R4", "stalled warp remaining cycles", wt, 9);
  endtask

  task automatic t_load;
    int wt;
    send(1, 1'b1, 9, FREE_A, FREE_B, 0, wt);
    check("R5", "load accepted", wt, 0);
    #1;
    check("R3", "pending load keeps warp_ready high", int'(warp_ready[1]), 1);
    check("R9", "iss_load for load", int'(iss_load), 1);
    fork
      send(1, 1'b0, 13, FREE_A, 9, 0, wt);
      drive_wb(2, 1, 9);
    join
    check("R6", "consumer on src_b waits for writeback", wt, 3);
    send(2, 1'b1, 20, FREE_A, FREE_B, 0, wt);
    fork
      send(2, 1'b0, 21, 20, FREE_B, 0, wt);
      begin
        drive_wb(1, 3, 20);
        drive_wb(2, 2, 20);
      end
    join
    check("R6", "writeback to other warp ignored", wt, 5);
  endtask

  task automatic t_same_cycle;
    int wt;
    send(0, 1'b1, 5, FREE_A, FREE_B, 0, wt);
    fork
      send(0, 1'b1, 5, FREE_A, FREE_B, 0, wt);
      drive_wb(0, 0, 5);
    join
    check("R7", "reload of pending dst accepted", wt, 0);
    fork
      send(0, 1'b0, 22, 5, FREE_B, 0, wt);
      drive_wb(2, 0, 5);
    join
    check("R7", "set wins over same-cycle clear", wt, 3);
  endtask

  task automatic t_both;
    int wt;
    send(3, 1'b1, 40, FREE_A, FREE_B, 4, wt);
    fork
      send(3, 1'b0, 42, 40, FREE_B, 0, wt);
      drive_wb(1, 3, 40);
    join
    check("R8", "stall longer than load", wt, 4);
    send(3, 1'b1, 41, FREE_A, FREE_B, 2, wt);
    fork
      send(3, 1'b0, 43, FREE_A, 41, 0, wt);
      drive_wb(5, 3, 41);
    join
    check("R8", "load longer than stall", wt, 6);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_back_to_back();
    t_stall();
    t_indep();
    t_load();
    t_same_cycle();
    t_both();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule